// File: doc/BRIEF.md
# Peripheral Request to Channel Mapper

This block sits between a set of peripheral request lines and a bank of DMA channels. Each request line has its own programmable 8-bit map entry that says whether the line is routed at all and, if so, which channel it drives. The block drives one request level per channel. It also marks the moments when that level changes, so the channel engine and the interrupt logic downstream can act on them.

Software programs the map through a simple byte-addressed register port. The first 64 entries sit in one word-aligned window. The remaining entries sit in a second, separate window. A rising channel level produces a one-cycle request-after-stop pulse, and a falling level produces a one-cycle end-of-receive pulse. A sticky request-after-stop flag per channel records whether the last change of any request routed to that channel was a rise of the channel level.

Top module: `dma_req_router`

## Requirements
- R1: While reset is asserted and right after it, every map entry reads 0 and ch_req, ras_evt, eor_evt, ras_flag and cfg_err are all 0.
- R2: In a map entry, bit 7 is the valid flag and bits 4:0 are the target channel number. An accepted write stores all 8 bits, and the value reads back unchanged on cfg_rdata in the same cycle as the address is presented.
- R3: Entry i (i < 64) is at byte address LO_BASE + 4*i (0x100 + 4*i by default). Entry i (64 <= i < 75) is at HI_BASE + 4*(i-64) (0x1100 + 4*(i-64) by default). Unaligned addresses and addresses outside both windows read 0, and writes to them change no entry.
- R4: A request whose map entry has bit 7 clear has no effect on ch_req, ras_evt, eor_evt or ras_flag.
- R5: ch_req[c] is the OR of all requests whose valid entry names channel c. It is registered, so it reflects req_in one clock after req_in changes.
- R6: ras_evt[c] is a one-cycle pulse in the same cycle that ch_req[c] goes from 0 to 1.
- R7: eor_evt[c] is a one-cycle pulse in the same cycle that ch_req[c] goes from 1 to 0.
- R8: ras_flag[c] is set when ch_req[c] rises. It is cleared when any request mapped to channel c changes without a rise of ch_req[c]. Otherwise it holds its value.
- R9: A write with bit 7 set and a channel number at or above NUM_CH (16 by default) is not stored. cfg_err pulses for one cycle after that write.
- R10: ras_evt[c] and eor_evt[c] are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_in | input | NUM_REQ | Peripheral request levels |
| cfg_we | input | 1 | Map write strobe |
| cfg_addr | input | ADDR_W | Byte address of map entry |
| cfg_wdata | input | 8 | Map write data |
| cfg_rdata | output | 8 | Map read data (combinational) |
| cfg_err | output | 1 | Rejected write, one cycle after it |
| ch_req | output | NUM_CH | Per-channel request level |
| ras_evt | output | NUM_CH | Request-after-stop pulse per channel |
| eor_evt | output | NUM_CH | End-of-receive pulse per channel |
| ras_flag | output | NUM_CH | Sticky request-after-stop flag |

## Verification
Two situations can fall in the same clock cycle: one request routed to a channel rises while another request routed to the same channel falls, and a map write lands in the same cycle as a request edge. The bench provokes the first by routing two requests to one channel and swapping their levels in a single step. It expects ch_req to stay high, no pulse in either direction, and ras_flag to be cleared. For the second, it drives a request edge together with a write that remaps that request. It expects the outcome to follow the map as it was before the write.

// File: rtl/dma_req_router.sv
module dma_req_router #(
  parameter int NUM_REQ = 75,
  parameter int NUM_CH  = 16,
  parameter int LO_CNT  = 64,
  parameter int ADDR_W  = 13,
  parameter logic [ADDR_W-1:0] LO_BASE = 13'h100,
  parameter logic [ADDR_W-1:0] HI_BASE = 13'h1100
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_REQ-1:0] req_in,
  input  logic               cfg_we,
  input  logic [ADDR_W-1:0]  cfg_addr,
  input  logic [7:0]         cfg_wdata,
  output logic [7:0]         cfg_rdata,
  output logic               cfg_err,
  output logic [NUM_CH-1:0]  ch_req,
  output logic [NUM_CH-1:0]  ras_evt,
  output logic [NUM_CH-1:0]  eor_evt,
  output logic [NUM_CH-1:0]  ras_flag
);
  localparam int HI_CNT = NUM_REQ - LO_CNT;
  localparam int IDX_W  = $clog2(NUM_REQ);
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam logic [ADDR_W-1:0] LO_SPAN = ADDR_W'(4 * LO_CNT);
  localparam logic [ADDR_W-1:0] HI_SPAN = ADDR_W'(4 * HI_CNT);
  localparam logic [5:0] CH_LIM = 6'(NUM_CH);

  logic [7:0]         map_q [NUM_REQ];
  logic [NUM_REQ-1:0] req_q;
  logic [NUM_CH-1:0]  lvl_n, touch;
  logic [ADDR_W-1:0]  lo_off, hi_off;
  logic               lo_hit, hi_hit, hit, bad_ch, wr_ok;
  logic [IDX_W-1:0]   idx;

  assign lo_off = cfg_addr - LO_BASE;
  assign hi_off = cfg_addr - HI_BASE;
  assign lo_hit = (cfg_addr >= LO_BASE) && (lo_off < LO_SPAN) && (lo_off[1:0] == 2'b00);
  assign hi_hit = (cfg_addr >= HI_BASE) && (hi_off < HI_SPAN) && (hi_off[1:0] == 2'b00);
  assign hit    = lo_hit | hi_hit;
  assign idx    = lo_hit ? IDX_W'(lo_off >> 2) : IDX_W'(LO_CNT) + IDX_W'(hi_off >> 2);
  assign bad_ch = cfg_wdata[7] && ({1'b0, cfg_wdata[4:0]} >= CH_LIM);
  assign wr_ok  = cfg_we && hit && !bad_ch;
  assign cfg_rdata = hit ? map_q[idx] : 8'h00;

  always_comb begin
    lvl_n = '0;
    touch = '0;
    for (int r = 0; r < NUM_REQ; r++) begin
      if (map_q[r][7]) begin
        lvl_n[map_q[r][CH_W-1:0]] = lvl_n[map_q[r][CH_W-1:0]] | req_in[r];
        touch[map_q[r][CH_W-1:0]] = touch[map_q[r][CH_W-1:0]] | (req_in[r] ^ req_q[r]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NUM_REQ; r++) map_q[r] <= 8'h00;
      req_q    <= '0;
      ch_req   <= '0;
      ras_evt  <= '0;
      eor_evt  <= '0;
      ras_flag <= '0;
      cfg_err  <= 1'b0;
    end else begin
      if (wr_ok) map_q[idx] <= cfg_wdata;
      req_q    <= req_in;
      ch_req   <= lvl_n;
      ras_evt  <= lvl_n & ~ch_req;
      eor_evt  <= ~lvl_n & ch_req;
      ras_flag <= (lvl_n & ~ch_req) | (ras_flag & ~touch);
      cfg_err  <= cfg_we && hit && bad_ch;
    end
  end

  a_r6_rise_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ras_evt == (ch_req & ~$past(ch_req)));
  a_r7_fall_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    eor_evt == (~ch_req & $past(ch_req)));
  a_r10_no_both: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_evt & eor_evt) == '0);
  a_r8_flag_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_evt & ~ras_flag) == '0);
  a_r9_err_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> $past(cfg_we));
endmodule

// File: tb/dma_req_router_bench.sv
module dma_req_router_bench;
  localparam int CLK_NS = 10;
  localparam int NR = 75;
  localparam int NC = 16;

  typedef struct {
    logic [NC-1:0] lvl, ras, eor, flg;
    logic          err;
    string         tag;
  } item_t;

  logic clk = 0, rst_n = 0;
  logic [NR-1:0] req_in = '0;
  logic cfg_we = 0;
  logic [12:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic cfg_err;
  logic [NC-1:0] ch_req, ras_evt, eor_evt, ras_flag;

  dma_req_router u_dma_req_router (
    .clk(clk), .rst_n(rst_n), .req_in(req_in), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .cfg_err(cfg_err), .ch_req(ch_req), .ras_evt(ras_evt),
    .eor_evt(eor_evt), .ras_flag(ras_flag));

  always #(CLK_NS/2) clk = ~clk;

  int errors = 0, checks = 0;
  bit done = 0;
  item_t sq[$];
  logic [7:0] m_map [NR];
  logic [NR-1:0] m_req = '0;
  logic [NC-1:0] m_lvl = '0, m_flg = '0;

  function automatic logic [12:0] addr_of(int i);
    return (i < 64) ? 13'(32'h100 + 4*i) : 13'(32'h1100 + 4*(i-64));
  endfunction

  function automatic int idx_of(logic [12:0] a);
    for (int i = 0; i < NR; i++) if (addr_of(i) == a) return i;
    return -1;
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step(logic [NR-1:0] rv, logic we, logic [12:0] a, logic [7:0] d, string tag);
    item_t it;
    logic [NC-1:0] lvl, tch;
    int ix;
    @(negedge clk);
    req_in = rv; cfg_we = we; cfg_addr = a; cfg_wdata = d;
    lvl = '0; tch = '0;
    for (int r = 0; r < NR; r++)
      if (m_map[r][7]) begin
        lvl[m_map[r][3:0]] |= rv[r];
        tch[m_map[r][3:0]] |= rv[r] ^ m_req[r];
      end
    ix = idx_of(a);
    it.lvl = lvl;
    it.ras = lvl & ~m_lvl;
    it.eor = ~lvl & m_lvl;
    it.flg = (lvl & ~m_lvl) | (m_flg & ~tch);
    it.err = we && ix >= 0 && d[7] && d[4:0] >= NC;
    it.tag = tag;
    sq.push_back(it);
    if (we && ix >= 0 && !it.err) m_map[ix] = d;
    m_lvl = lvl; m_flg = it.flg; m_req = rv;
  endtask

  task automatic rd(logic [12:0] a, logic [7:0] exp, string tag);
    @(negedge clk);
    cfg_we = 0; cfg_addr = a;
    #1;
    chk(cfg_rdata === exp, tag, 32'(cfg_rdata), 32'(exp));
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #(CLK_NS/4);
      if (sq.size() > 0) begin
        item_t it;
        it = sq.pop_front();
        chk(ch_req === it.lvl,   {it.tag, " ch_req"},   32'(ch_req),   32'(it.lvl));
        chk(ras_evt === it.ras,  {it.tag, " ras_evt"},  32'(ras_evt),  32'(it.ras));
        chk(eor_evt === it.eor,  {it.tag, " eor_evt"},  32'(eor_evt),  32'(it.eor));
        chk(ras_flag === it.flg, {it.tag, " ras_flag"}, 32'(ras_flag), 32'(it.flg));
        chk(cfg_err === it.err,  {it.tag, " cfg_err"},  32'(cfg_err),  32'(it.err));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [NR-1:0] v;
    for (int i = 0; i < NR; i++) m_map[i] = 8'h00;
    repeat (3) @(negedge clk);
    #1;
    chk(ch_req === '0 && ras_evt === '0 && eor_evt === '0 && ras_flag === '0 && cfg_err === 0,
        "R1 outputs in reset", 32'({ch_req, ras_flag}), 32'h0);
    @(negedge clk); rst_n = 1;
    rd(addr_of(0), 8'h00, "R1 entry 0 after reset");
    rd(addr_of(74), 8'h00, "R1 entry 74 after reset");

    v = '0;
    step(v, 1, addr_of(3),  8'h82, "R2 write e3");
    step(v, 1, addr_of(70), 8'h82, "R3 write e70 high window");
    step(v, 1, addr_of(10), 8'h85, "R2 write e10");
    step(v, 1, addr_of(74), 8'h8F, "R3 write e74");
    step(v, 0, 13'h0, 8'h00, "R2 idle");
    rd(addr_of(3),  8'h82, "R2 readback e3");
    rd(addr_of(70), 8'h82, "R3 readback e70");
    rd(addr_of(74), 8'h8F, "R3 readback e74");
    rd(addr_of(63), 8'h00, "R3 readback e63");

    v[20] = 1; step(v, 0, 0, 0, "R4 unmapped rise");
    v[20] = 0; step(v, 0, 0, 0, "R4 unmapped fall");
    v[3] = 1;  step(v, 0, 0, 0, "R6 rise ch2");
    step(v, 0, 0, 0, "R6 pulse ends");
    v[70] = 1; step(v, 0, 0, 0, "R8 second req no rise");
    v[3] = 0;  step(v, 0, 0, 0, "R5 OR holds level");
    v[70] = 0; step(v, 0, 0, 0, "R7 fall ch2");
    v[70] = 1; step(v, 0, 0, 0, "R6 rise via e70");
    v[70] = 0; v[3] = 1; step(v, 0, 0, 0, "R10 swap on same channel");
    v[3] = 0; step(v, 0, 0, 0, "R7 fall after swap");
    v[74] = 1; v[10] = 1; step(v, 0, 0, 0, "R5 two channels rise");
    v[74] = 0; step(v, 0, 0, 0, "R7 ch15 fall only");

    v[10] = 0; step(v, 1, addr_of(10), 8'h86, "R5 edge with remap");
    step(v, 0, 0, 0, "R2 idle after remap");
    rd(addr_of(10), 8'h86, "R2 remap stored");

    step(v, 1, addr_of(5), 8'h90, "R9 bad channel 16");
    step(v, 1, addr_of(5), 8'h9F, "R9 bad channel 31");
    step(v, 0, 0, 0, "R9 idle");
    rd(addr_of(5), 8'h00, "R9 entry unchanged");
    step(v, 1, 13'h101, 8'h81, "R3 unaligned write");
    step(v, 1, 13'h112C, 8'h81, "R3 past high window");
    step(v, 1, 13'h00FC, 8'h81, "R3 below low window");
    step(v, 0, 0, 0, "R3 idle");
    rd(13'h101, 8'h00, "R3 unaligned read");
    rd(13'h112C, 8'h00, "R3 outside read");
    rd(addr_of(0), 8'h00, "R3 e0 untouched");

    step(v, 1, addr_of(10), 8'h06, "R4 clear valid e10");
    v[10] = 1; step(v, 0, 0, 0, "R4 invalid entry rise");
    v[10] = 0; step(v, 0, 0, 0, "R4 invalid entry fall");

    for (int i = 0; i < NR; i++)
      step(v, 1, addr_of(i), 8'(8'h80 | (i % NC)), "R2 fill all");
    step(v, 0, 0, 0, "R2 idle after fill");
    for (int i = 0; i < NR; i++)
      rd(addr_of(i), 8'(8'h80 | (i % NC)), "R3 sweep readback");
    v = '1; step(v, 0, 0, 0, "R6 all channels rise");
    v = '0; step(v, 0, 0, 0, "R7 all channels fall");
    step(v, 0, 0, 0, "R10 quiet");

    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule